// File: doc/BRIEF.md
# Lockable Two-Way Instruction Cache

This block is a read-only instruction cache between a processor fetch port and a slower memory port. It holds 1 KB of code as two ways of 32 sets. Each line has four 32-bit words. A fetch that hits is answered in the same cycle it is presented. A fetch that misses starts a line fill. The fill reads the four words of the line from memory one at a time, starting at word 0. The requested word is handed back in the cycle it arrives from memory. The line becomes usable only after the fourth word has been written.

Code can be pinned in the cache. While the lock-enable input is high, every line completed by a fill is marked locked. A locked way is never chosen as a victim. If both ways of a set are locked, a miss in that set reads only the one requested word from memory and allocates nothing. The invalidate input drops every resident line but keeps all lock marks. A pinned way therefore stays reserved until reset.

Top module: `icache_lock2w`

## Requirements
- R1: After reset no line is valid or locked, every set's recency mark is cleared, and `fetchReady` and `memReq` are low.
- R2: A fetch presented while the cache is idle that matches a valid line raises `fetchReady` in that same cycle, with the addressed word on `fetchData`, and makes no memory request.
- R3: A fill requests the four words of the line in ascending order at addresses line base + 0, 4, 8 and 12. The requested word is returned on `fetchData` with `fetchReady` in the cycle `memValid` brings it.
- R4: A filled line is marked valid only when its fourth word is written. New fetches are not accepted until the fill has finished. The first fetch to that line after the fill hits without any memory traffic.
- R5: The victim is chosen in this order: an unlocked invalid way 0, then an unlocked invalid way 1, then the least recently used of the unlocked ways. A hit or a fill makes that way the most recently used. A set never holds the same tag in both ways.
- R6: A locked way is never chosen as a victim, whether or not it is valid.
- R7: When both ways of the addressed set are locked, a miss makes exactly one word-aligned memory request for the requested word, returns it, and leaves the cache contents unchanged.
- R8: A line completed while `lockEnable` is high becomes locked. A line completed while it is low stays unlocked.
- R9: `invalidate` sampled while idle clears all valid bits and leaves every lock bit unchanged. It takes priority over a fetch in the same cycle, so that fetch gets no `fetchReady` in that cycle.
- R10: Fetch addresses are split as follows: bits [3:2] select the word, bits [8:4] select the set, and bits [31:9] form the tag.
- R11: `memReq` stays high with `memAddr` unchanged from the cycle it rises until the cycle `memValid` answers it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchReq | input | 1 | Fetch request, held until `fetchReady` |
| fetchAddr | input | 32 | Byte address of the instruction word |
| fetchReady | output | 1 | One-cycle pulse: `fetchData` is valid |
| fetchData | output | 32 | Instruction word returned |
| invalidate | input | 1 | Drop all lines, keep lock marks |
| lockEnable | input | 1 | Lines completed while high are locked |
| memReq | output | 1 | Memory word read request |
| memAddr | output | 32 | Word-aligned memory address |
| memValid | input | 1 | One-cycle pulse: `memData` answers `memReq` |
| memData | input | 32 | Word read from memory |

## Verification
The hardest case to reach from the ports is a set whose two ways are both locked, especially after an invalidate. In that state the locked ways are empty but still refuse allocation, so every miss must become a single-word bypass. The stimulus reaches it in several steps. It fills two lines of one set with `lockEnable` high. It confirms that a third tag in that set bypasses twice in a row. It then fires `invalidate` in the same cycle as a fetch that would hit, and checks that the old line now comes back through a bypass rather than a fill. A second set has only one locked way; there a fill must land in the unlocked way even when recency points at the locked one. After this, a mid-test reset is applied and the bench confirms that the lock marks are gone.

// File: rtl/ic_pkg.sv
package ic_pkg;

  localparam int WORD_BITS = 32;

  typedef struct packed {
    logic invAll;    // clear every valid bit
    logic touch;     // hit: mark touchWay most recent
    logic touchWay;
    logic memWr;     // write memData into the fill line at fillWord
    logic fillWay;
    logic commit;    // last word written: set tag, valid, lock
    logic lockNew;
  } icStrobe_t;

endpackage

// File: rtl/ic_datapath.sv
module ic_datapath
  import ic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int OFF_W     = WSEL_W + 2,
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LOC_W     = IDX_W + WSEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  icStrobe_t            strb,
  input  logic [ADDR_W-1:0]    lookAddr,
  input  logic [WSEL_W-1:0]    fillWord,
  input  logic [WORD_BITS-1:0] memData,
  output logic [1:0]           hitVec,
  output logic [WORD_BITS-1:0] hitData,
  output logic [1:0]           setValid,
  output logic [1:0]           setLock,
  output logic                 setLru
);

  logic [TAG_W-1:0]     tagMem  [2][SETS];
  logic [WORD_BITS-1:0] dataMem [2][SETS*LINE_WORDS];
  logic [SETS-1:0]      validW  [2];
  logic [SETS-1:0]      lockW   [2];
  logic [SETS-1:0]      lruBits;

  logic [IDX_W-1:0]     setIdx;
  logic [TAG_W-1:0]     tagIn;
  logic [WSEL_W-1:0]    wordIdx;
  logic [WORD_BITS-1:0] wayWord [2];

  assign setIdx  = lookAddr[OFF_W +: IDX_W];
  assign tagIn   = lookAddr[ADDR_W-1 -: TAG_W];
  assign wordIdx = lookAddr[2 +: WSEL_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    assign hitVec[w]   = validW[w][setIdx] && (tagMem[w][setIdx] == tagIn);
    assign setValid[w] = validW[w][setIdx];
    assign setLock[w]  = lockW[w][setIdx];
    assign wayWord[w]  = dataMem[w][LOC_W'({setIdx, wordIdx})];
  end

  assign hitData = hitVec[1] ? wayWord[1] : wayWord[0];
  assign setLru  = lruBits[setIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < 2; w++) begin
        validW[w] <= '0;
        lockW[w]  <= '0;
      end
      lruBits <= '0;
    end else begin
      if (strb.invAll) begin
        for (int w = 0; w < 2; w++) validW[w] <= '0;
      end else if (strb.commit) begin
        validW[strb.fillWay][setIdx] <= 1'b1;
        lockW[strb.fillWay][setIdx]  <= strb.lockNew;
      end
      if (strb.commit) lruBits[setIdx] <= ~strb.fillWay;
      else if (strb.touch) lruBits[setIdx] <= ~strb.touchWay;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) tagMem[strb.fillWay][setIdx] <= tagIn;
    if (strb.memWr) dataMem[strb.fillWay][LOC_W'({setIdx, fillWord})] <= memData;
  end

  // R6: the control never completes a fill into a locked way
  p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> !lockW[strb.fillWay][setIdx]);

  // R5: a tag is resident in at most one way of a set
  p_single_hit_r5: assert property (@(posedge clk) disable iff (!rstN)
    $countones(hitVec) <= 1);

  // R9: invalidate leaves lock marks untouched
  p_inv_keeps_lock_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.invAll |=> ($stable(lockW[0]) && $stable(lockW[1])));

  // R9: invalidate empties the cache
  p_inv_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.invAll |=> (validW[0] == '0 && validW[1] == '0));

endmodule

// File: rtl/ic_control.sv
module ic_control
  import ic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int OFF_W     = WSEL_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              invalidate,
  input  logic              lockEnable,
  input  logic              memValid,
  input  logic [1:0]        hitVec,
  input  logic [1:0]        setValid,
  input  logic [1:0]        setLock,
  input  logic              setLru,
  output icStrobe_t         strb,
  output logic [ADDR_W-1:0] lookAddr,
  output logic [WSEL_W-1:0] fillWord,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  output logic              fetchReady,
  output logic              fromMem
);

  localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(LINE_WORDS - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_BYPASS} ctlState_t;

  ctlState_t         state, nextState;
  logic [ADDR_W-1:0] reqAddr;
  logic [WSEL_W-1:0] wordCnt;
  logic              fillWayR;
  logic              victim;
  logic              bothLocked;
  logic              missStart;

  assign bothLocked = setLock[0] && setLock[1];

  always_comb begin
    if (!setLock[0] && !setValid[0])      victim = 1'b0;
    else if (!setLock[1] && !setValid[1]) victim = 1'b1;
    else if (setLock[0])                  victim = 1'b1;
    else if (setLock[1])                  victim = 1'b0;
    else                                  victim = setLru;
  end

  assign lookAddr = (state == S_IDLE) ? fetchAddr : reqAddr;
  assign fillWord = wordCnt;
  assign memReq   = (state != S_IDLE);
  assign memAddr  = (state == S_FILL) ? {reqAddr[ADDR_W-1:OFF_W], wordCnt, 2'b00}
                                      : {reqAddr[ADDR_W-1:2], 2'b00};
  assign missStart = (state == S_IDLE) && !invalidate && fetchReq && (hitVec == 2'b00);

  always_comb begin
    strb       = '0;
    fetchReady = 1'b0;
    fromMem    = 1'b0;
    nextState  = state;
    strb.fillWay = fillWayR;
    case (state)
      S_IDLE: begin
        if (invalidate) begin
          strb.invAll = 1'b1;
        end else if (fetchReq) begin
          if (hitVec != 2'b00) begin
            fetchReady    = 1'b1;
            strb.touch    = 1'b1;
            strb.touchWay = hitVec[1];
          end else begin
            nextState = bothLocked ? S_BYPASS : S_FILL;
          end
        end
      end
      S_FILL: begin
        if (memValid) begin
          strb.memWr = 1'b1;
          if (wordCnt == reqAddr[2 +: WSEL_W]) begin
            fetchReady = 1'b1;
            fromMem    = 1'b1;
          end
          if (wordCnt == LAST_WORD) begin
            strb.commit  = 1'b1;
            strb.lockNew = lockEnable;
            nextState    = S_IDLE;
          end
        end
      end
      S_BYPASS: begin
        if (memValid) begin
          fetchReady = 1'b1;
          fromMem    = 1'b1;
          nextState  = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      reqAddr  <= '0;
      wordCnt  <= '0;
      fillWayR <= 1'b0;
    end else begin
      state <= nextState;
      if (missStart) begin
        reqAddr  <= fetchAddr;
        wordCnt  <= '0;
        fillWayR <= victim;
      end else if (state == S_FILL && memValid) begin
        wordCnt <= wordCnt + 1'b1;
      end
    end
  end

  // R11: an outstanding memory read is held steady until answered
  p_mem_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memValid) |=> (memReq && $stable(memAddr)));

  // R7: a bypass read is a single word, then the cache is idle again
  p_bypass_one_r7: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BYPASS && memValid) |=> !memReq);

  // R2: data is only offered to a requester that is waiting for it
  p_ready_needs_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchReady |-> fetchReq);

  // R4: a fill runs back to back with no idle gap until its last word
  p_fill_continues_r4: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_FILL && memValid && wordCnt != LAST_WORD) |=> memReq);

endmodule

// File: rtl/icache_lock2w.sv
module icache_lock2w
  import ic_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_WORDS = 4,
  localparam int WSEL_W    = $clog2(LINE_WORDS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 fetchReq,
  input  logic [ADDR_W-1:0]    fetchAddr,
  output logic                 fetchReady,
  output logic [WORD_BITS-1:0] fetchData,
  input  logic                 invalidate,
  input  logic                 lockEnable,
  output logic                 memReq,
  output logic [ADDR_W-1:0]    memAddr,
  input  logic                 memValid,
  input  logic [WORD_BITS-1:0] memData
);

  icStrobe_t            strb;
  logic [ADDR_W-1:0]    lookAddr;
  logic [WSEL_W-1:0]    fillWord;
  logic [1:0]           hitVec, setValid, setLock;
  logic                 setLru;
  logic [WORD_BITS-1:0] hitData;
  logic                 fromMem;

  ic_control #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) i_ctl (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .invalidate(invalidate), .lockEnable(lockEnable), .memValid(memValid),
    .hitVec(hitVec), .setValid(setValid), .setLock(setLock), .setLru(setLru),
    .strb(strb), .lookAddr(lookAddr), .fillWord(fillWord), .memReq(memReq),
    .memAddr(memAddr), .fetchReady(fetchReady), .fromMem(fromMem)
  );

  ic_datapath #(.ADDR_W(ADDR_W), .SETS(SETS), .LINE_WORDS(LINE_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .lookAddr(lookAddr), .fillWord(fillWord),
    .memData(memData), .hitVec(hitVec), .hitData(hitData), .setValid(setValid),
    .setLock(setLock), .setLru(setLru)
  );

  assign fetchData = fromMem ? memData : hitData;

endmodule

// File: tb/test_icache_lock2w.sv
module test_icache_lock2w;

  localparam int LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        fetchReq = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic        fetchReady;
  logic [31:0] fetchData;
  logic        invalidate = 1'b0;
  logic        lockEnable = 1'b0;
  logic        memReq;
  logic [31:0] memAddr;
  logic        memValid = 1'b0;
  logic [31:0] memData = '0;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  icache_lock2w i_icache_lock2w (
    .clk(clk), .rstN(rstN), .fetchReq(fetchReq), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchData(fetchData), .invalidate(invalidate),
    .lockEnable(lockEnable), .memReq(memReq), .memAddr(memAddr),
    .memValid(memValid), .memData(memData)
  );

  function automatic logic [31:0] memFn(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // memory responder: answers each request after LAT cycles, logs addresses
  logic [31:0] memLog[$];
  bit          respBusy = 0;
  int          respCnt  = 0;
  logic [31:0] respAddr;

  always @(negedge clk) begin
    memValid <= 1'b0;
    if (!rstN) begin
      respBusy = 0;
    end else if (!respBusy) begin
      if (memReq) begin
        respBusy = 1;
        respCnt  = LAT;
        respAddr = memAddr;
        memLog.push_back(memAddr);
      end
    end else begin
      chk(memReq && memAddr == respAddr, "R11", memAddr, respAddr);
      respCnt--;
      if (respCnt == 0) begin
        memValid <= 1'b1;
        memData  <= memFn(respAddr);
        respBusy = 0;
      end
    end
  end

  // behavioural model: per set, two slots with tag, valid, lock, and recency
  bit          mValid[2][32];
  bit          mLock [2][32];
  int unsigned mTag  [2][32];
  bit          mLru  [32];

  function automatic void modelReset();
    for (int s = 0; s < 32; s++) begin
      mLru[s] = 0;
      for (int w = 0; w < 2; w++) begin mValid[w][s] = 0; mLock[w][s] = 0; mTag[w][s] = 0; end
    end
  endfunction

  task automatic doReset();
    rstN = 1'b0;
    fetchReq = 1'b0;
    invalidate = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(fetchReady == 1'b0, "R1 fetchReady", 32'(fetchReady), 0);
    chk(memReq == 1'b0, "R1 memReq", 32'(memReq), 0);
    @(negedge clk);
    rstN = 1'b1;
    modelReset();
    @(negedge clk);
  endtask

  // kind: 0 hit, 1 fill, 2 bypass
  task automatic doFetch(logic [31:0] addr, string req);
    int unsigned s   = (addr >> 4) & 31;
    int unsigned tg  = addr >> 9;
    int          kind;
    int          hw  = -1;
    int          vw  = 0;
    int          cyc = 0;
    bit          firstReady;
    logic [31:0] base = addr & ~32'hF;
    for (int w = 0; w < 2; w++) if (mValid[w][s] && mTag[w][s] == tg) hw = w;
    if (hw >= 0) kind = 0;
    else if (mLock[0][s] && mLock[1][s]) kind = 2;
    else begin
      kind = 1;
      if (!mLock[0][s] && !mValid[0][s]) vw = 0;
      else if (!mLock[1][s] && !mValid[1][s]) vw = 1;
      else if (mLock[0][s]) vw = 1;
      else if (mLock[1][s]) vw = 0;
      else vw = mLru[s];
    end
    memLog.delete();
    fetchReq = 1'b1;
    fetchAddr = addr;
    #1;
    firstReady = fetchReady;
    while (!fetchReady && cyc < 100) begin
      @(negedge clk); #1; cyc++;
    end
    chk(fetchReady == 1'b1, {req, " ready"}, 32'(fetchReady), 1);
    chk(fetchData == memFn(addr & ~32'h3), {req, " data"}, fetchData, memFn(addr & ~32'h3));
    chk(firstReady == (kind == 0), {req, " same-cycle hit"}, 32'(firstReady), 32'(kind == 0));
    @(negedge clk);
    fetchReq = 1'b0;
    #1;
    cyc = 0;
    while (memReq && cyc < 100) begin @(negedge clk); #1; cyc++; end
    if (kind == 0) begin
      chk(memLog.size() == 0, {req, " no memory traffic"}, memLog.size(), 0);
      mLru[s] = !hw[0];
    end else if (kind == 2) begin
      chk(memLog.size() == 1, {req, " bypass count"}, memLog.size(), 1);
      if (memLog.size() == 1)
        chk(memLog[0] == (addr & ~32'h3), {req, " bypass addr"}, memLog[0], addr & ~32'h3);
    end else begin
      chk(memLog.size() == 4, {req, " fill count"}, memLog.size(), 4);
      for (int k = 0; k < 4; k++)
        if (k < memLog.size())
          chk(memLog[k] == base + 32'(4*k), {req, " fill order R3"}, memLog[k], base + 32'(4*k));
      mValid[vw][s] = 1;
      mTag[vw][s]   = tg;
      mLock[vw][s]  = lockEnable;
      mLru[s]       = !vw[0];
    end
  endtask

  function automatic logic [31:0] mk(int unsigned tg, int unsigned s, int unsigned wd);
    return (tg << 9) | (s << 4) | (wd << 2);
  endfunction

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    modelReset();
    doReset();                                   // R1
    // R1: empty after reset, R3 fill with requested word 2, R10 split
    doFetch(mk(1, 5, 2), "R3 miss word2");
    // R4: first fetches after fill hit; R2 same-cycle hits
    doFetch(mk(1, 5, 0), "R4 hit after fill");
    doFetch(mk(1, 5, 3), "R2 hit word3");
    doFetch(mk(1, 5, 1), "R2 hit word1");
    // R10: same set bits, other tag -> separate line; R5 invalid way first
    doFetch(mk(2, 5, 3), "R5 fill way1 R10");
    doFetch(mk(1, 5, 1), "R5 touch way0");
    doFetch(mk(3, 5, 0), "R5 LRU victim");
    doFetch(mk(1, 5, 2), "R5 recent kept");
    doFetch(mk(2, 5, 1), "R5 evicted refill");
    doFetch(mk(7, 6, 0), "R10 neighbour set");
    // R8, R6: one locked way in set 9
    lockEnable = 1'b1;
    doFetch(mk(4, 9, 1), "R8 locked fill");
    lockEnable = 1'b0;
    doFetch(mk(5, 9, 2), "R8 unlocked fill");
    doFetch(mk(4, 9, 0), "R6 hit locked");
    doFetch(mk(6, 9, 3), "R6 skip locked");
    doFetch(mk(7, 9, 0), "R6 skip locked again");
    doFetch(mk(4, 9, 2), "R6 locked resident");
    // R7: both ways locked in set 12
    lockEnable = 1'b1;
    doFetch(mk(8, 12, 0), "R7 lock way0");
    doFetch(mk(9, 12, 1), "R7 lock way1");
    lockEnable = 1'b0;
    doFetch(mk(10, 12, 2), "R7 bypass");
    doFetch(mk(10, 12, 2), "R7 no allocation");
    doFetch(mk(8, 12, 3), "R7 pinned hit");
    // R9: invalidate beats a hitting fetch, locks survive
    @(negedge clk);
    invalidate = 1'b1;
    fetchReq = 1'b1;
    fetchAddr = mk(8, 12, 3);
    #1;
    chk(fetchReady == 1'b0, "R9 invalidate priority", 32'(fetchReady), 0);
    @(negedge clk);
    invalidate = 1'b0;
    fetchReq = 1'b0;
    for (int s = 0; s < 32; s++) begin mValid[0][s] = 0; mValid[1][s] = 0; end
    @(negedge clk);
    doFetch(mk(8, 12, 3), "R9 locks kept bypass");
    doFetch(mk(4, 9, 0), "R9 refill unlocked way");
    doFetch(mk(1, 5, 2), "R9 line dropped");
    // R1: reset clears locks
    doReset();
    doFetch(mk(8, 12, 0), "R1 locks cleared fill");
    doFetch(mk(9, 12, 0), "R1 second way fill");
    doFetch(mk(10, 12, 0), "R1 replace after reset");
    summary();
  end

endmodule